// File: doc/BRIEF.md
# Slot-Limited Slave Arbiter with Idle Parking

This block decides which of up to twelve bus masters owns one shared slave port. Each master has a two-bit priority. When the port is free, the highest-priority requester wins, and equal-priority requesters take turns in round-robin order.

A master that holds the port keeps it until one of two things happens. Either it drops its request, or its hold time reaches a programmable cycle budget while another master is waiting. In the second case the grant moves only at a cycle that the surrounding logic marks as a safe switching point.

When no master is requesting, a parking policy chooses where the port rests:
- **Disconnected.** The next access pays one cycle of grant latency.
- **Last owner.** The port stays with the master that used it last.
- **Fixed master.** The port parks on a chosen master.

A master that finds the port already parked on it starts at once, with no added cycle. The data path and the configuration registers lie outside this block. It only produces the grant vector and the index of the connected master.

Top module: `slotarb_top`

## Requirements
- R1: `grant_o` has at most one bit set. Whenever it is nonzero, the set bit is at position `owner_o`.
- R2: After reset, `grant_o` is all zeros and `owner_o` is 0.
- R3: In an arbitration, the requester with the numerically largest priority wins. Master m's priority is `prio_i[2m+1:2m]`.
- R4: Among requesters with the same top priority, the winner is the first one found when searching upward, with wraparound, from the master after the one most recently granted by arbitration. Parking does not count as a grant. After reset the search starts at master 0.
- R5: If the owner is requesting, `slot_lim_i` = L is nonzero, and another master is requesting, the owner is displaced once it has held the grant for L cycles. A value of L = 0 means no limit.
- R6: While the connected master is requesting and `rearb_i` is low, neither the grant nor the owner changes on the next edge.
- R7: With `park_mode_i` = 0 (value 3 behaves the same way), the grant falls to zero one edge after all requests are gone.
- R8: With `park_mode_i` = 1, the grant stays on the last connected master while no master requests.
- R9: With `park_mode_i` = 2 and no requests, the port parks on master `park_fixed_i` one edge later. If that index is 12 or more, the port is disconnected instead.
- R10: If the connected master is not requesting, or no master is connected, a new request is granted at the next clock edge.
- R11: A master whose request finds the grant already parked on it sees its grant bit set in that same cycle, and keeps the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 12 | Per-master request lines |
| rearb_i | input | 1 | High in cycles where the grant may move away from a requesting owner |
| prio_i | input | 24 | Two-bit priority per master, packed by master index |
| slot_lim_i | input | 9 | Maximum hold time in cycles; 0 means unlimited |
| park_mode_i | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed master, 3 none |
| park_fixed_i | input | 4 | Master index used by the fixed parking policy |
| grant_o | output | 12 | One-hot grant, or all zeros when disconnected |
| owner_o | output | 4 | Index of the connected or last connected master |

## Verification
A corrupted round-robin pointer does not show at once. It shows at the next tie between equal-priority masters, which is granted to the wrong master one edge after the requests appear. A hold counter that is off by one moves the displacement edge by a cycle, so the bench counts the exact number of cycles the owner holds the grant. A wrong parking decision shows at the ports one edge after the requests fall away: `grant_o` is nonzero when it should be cleared, or points at the wrong master.

// File: rtl/slotarb_pkg.sv
package slotarb_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_e;

endpackage

// File: rtl/slotarb_pick.sv
module slotarb_pick #(
    parameter int NUM_M  = 12,
    parameter int PRIO_W = 2,
    localparam int IDX_W = $clog2(NUM_M)
) (
    input  logic [NUM_M-1:0]        mask_i,
    input  logic [NUM_M*PRIO_W-1:0] prio_i,
    input  logic [IDX_W-1:0]        ptr_i,
    output logic                    any_o,
    output logic [IDX_W-1:0]        idx_o
);

    logic [PRIO_W-1:0] top_lvl;
    logic              found;

    // Highest priority value present among the masked requesters.
    always_comb begin
        top_lvl = '0;
        for (int m = 0; m < NUM_M; m++) begin
            if (mask_i[m] && (prio_i[m*PRIO_W +: PRIO_W] > top_lvl)) begin
                top_lvl = prio_i[m*PRIO_W +: PRIO_W];
            end
        end
    end

    // Rotating search that starts at the master after ptr_i.
    always_comb begin
        found = 1'b0;
        idx_o = '0;
        for (int off = 1; off <= NUM_M; off++) begin
            int cand;
            cand = (int'(ptr_i) + off) % NUM_M;
            if (!found && mask_i[cand] &&
                (prio_i[cand*PRIO_W +: PRIO_W] == top_lvl)) begin
                found = 1'b1;
                idx_o = IDX_W'(cand);
            end
        end
    end

    assign any_o = |mask_i;

endmodule

// File: rtl/slotarb_timer.sv
module slotarb_timer #(
    parameter int SLOT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    input  logic [SLOT_W-1:0] lim_i,
    output logic              exp_o
);

    logic [SLOT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // cnt_q holds the number of edges already kept, so the current cycle is hold cycle cnt_q+1.
    assign exp_o = (lim_i != '0) && (cnt_q >= (lim_i - SLOT_W'(1)));

endmodule

// File: rtl/slotarb_top.sv
module slotarb_top #(
    parameter int NUM_M  = 12,
    parameter int PRIO_W = 2,
    parameter int SLOT_W = 9,
    parameter int FIX_W  = 4,
    localparam int IDX_W = $clog2(NUM_M)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_M-1:0]        req_i,
    input  logic                    rearb_i,
    input  logic [NUM_M*PRIO_W-1:0] prio_i,
    input  logic [SLOT_W-1:0]       slot_lim_i,
    input  logic [1:0]              park_mode_i,
    input  logic [FIX_W-1:0]        park_fixed_i,
    output logic [NUM_M-1:0]        grant_o,
    output logic [IDX_W-1:0]        owner_o
);
    import slotarb_pkg::*;

    typedef struct packed {
        logic             conn;
        logic [IDX_W-1:0] cur;
        logic [IDX_W-1:0] rr;
    } arb_st_t;

    arb_st_t          st_d, st_q;
    park_e            mode;
    logic             own_req;
    logic [NUM_M-1:0] cand_mask;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    logic             tmr_clr, tmr_inc, slot_exp;

    assign mode    = park_e'(park_mode_i);
    assign grant_o = st_q.conn ? (NUM_M'(1) << st_q.cur) : '0;
    assign owner_o = st_q.cur;
    assign own_req = st_q.conn && req_i[st_q.cur];

    // A requesting owner competes only against the others.
    assign cand_mask = own_req ? (req_i & ~grant_o) : req_i;

    slotarb_pick #(.NUM_M(NUM_M), .PRIO_W(PRIO_W)) u_pick (
        .mask_i (cand_mask),
        .prio_i (prio_i),
        .ptr_i  (st_q.rr),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    slotarb_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmr_clr),
        .inc_i (tmr_inc),
        .lim_i (slot_lim_i),
        .exp_o (slot_exp)
    );

    always_comb begin
        st_d    = st_q;
        tmr_clr = 1'b1;
        tmr_inc = 1'b0;
        if (own_req) begin
            if (rearb_i && slot_exp && pick_any) begin
                st_d.cur = pick_idx;
                st_d.rr  = pick_idx;
            end else begin
                tmr_clr = 1'b0;
                tmr_inc = 1'b1;
            end
        end else if (pick_any) begin
            st_d.conn = 1'b1;
            st_d.cur  = pick_idx;
            st_d.rr   = pick_idx;
        end else begin
            unique case (mode)
                PARK_LAST:  st_d.conn = st_q.conn;
                PARK_FIXED: begin
                    if (int'(park_fixed_i) < NUM_M) begin
                        st_d.conn = 1'b1;
                        st_d.cur  = IDX_W'(park_fixed_i);
                    end else begin
                        st_d.conn = 1'b0;
                    end
                end
                default:    st_d.conn = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.conn <= 1'b0;
            st_q.cur  <= '0;
            st_q.rr   <= IDX_W'(NUM_M - 1);
        end else begin
            st_q <= st_d;
        end
    end

    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && ((grant_o == '0) || grant_o[owner_o]));

    a_r6_hold_without_rearb: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && req_i[owner_o] && !rearb_i)
        |=> (grant_o != '0) && (owner_o == $past(owner_o)));

    a_r7_none_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0 && (park_mode_i == 2'd0 || park_mode_i == 2'd3))
        |=> (grant_o == '0));

    a_r8_last_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0 && park_mode_i == 2'd1) |=> $stable(grant_o));

    a_r9_fixed_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0 && park_mode_i == 2'd2 && int'(park_fixed_i) < NUM_M)
        |=> (grant_o != '0) && (int'(owner_o) == int'($past(park_fixed_i))));

endmodule

// File: tb/tb_slotarb_top.sv
module tb_slotarb_top;
    localparam int NM = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req = '0;
    logic          rearb = 1'b1;
    logic [23:0]   prio = '0;
    logic [8:0]    lim = '0;
    logic [1:0]    mode = 2'd0;
    logic [3:0]    fixd = '0;
    logic [NM-1:0] grant;
    logic [3:0]    owner;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    slotarb_top dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .rearb_i(rearb), .prio_i(prio),
        .slot_lim_i(lim), .park_mode_i(mode), .park_fixed_i(fixd),
        .grant_o(grant), .owner_o(owner)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Leaves the port disconnected, with the round-robin pointer at master i.
    task automatic seed_ptr(input int i);
        mode = 2'd0; req = NM'(1) << i; step();
        req = '0; step();
    endtask

    task automatic t_reset();
        check("R2 grant after reset", int'(grant), 0);
        check("R2 owner after reset", int'(owner), 0);
    endtask

    task automatic t_none();
        mode = 2'd0; req = NM'(1) << 3; #1;
        check("R7 extra cycle before grant", int'(grant), 0);
        step();
        check("R10 grant next edge", int'(grant), 1 << 3);
        check("R1 owner matches", int'(owner), 3);
        req = '0; step();
        check("R7 release mode0", int'(grant), 0);
        mode = 2'd3; req = NM'(1) << 2; step();
        check("R10 grant mode3", int'(grant), 1 << 2);
        req = '0; step();
        check("R7 release mode3", int'(grant), 0);
    endtask

    task automatic t_last();
        mode = 2'd1; req = NM'(1) << 5; step();
        check("R10 grant m5", int'(grant), 1 << 5);
        req = '0; step(); step();
        check("R8 stays on last", int'(grant), 1 << 5);
        req = NM'(1) << 5; #1;
        check("R11 parked grant immediate", int'(grant), 1 << 5);
        step();
        check("R11 parked grant kept", int'(owner), 5);
        req = '0; step();
    endtask

    task automatic t_fixed();
        mode = 2'd2; fixd = 4'd7; req = NM'(1) << 1; step();
        check("R10 grant m1", int'(grant), 1 << 1);
        req = '0; step();
        check("R9 park on fixed", int'(grant), 1 << 7);
        check("R9 owner fixed", int'(owner), 7);
        req = NM'(1) << 7; #1;
        check("R11 fixed parked immediate", int'(grant), 1 << 7);
        step();
        check("R11 fixed kept", int'(grant), 1 << 7);
        req = '0; fixd = 4'd13; step();
        check("R9 out-of-range disconnects", int'(grant), 0);
        mode = 2'd0;
    endtask

    task automatic t_prio();
        seed_ptr(0);
        prio = '0;
        prio[2*2 +: 2] = 2'd1;
        prio[9*2 +: 2] = 2'd3;
        prio[10*2 +: 2] = 2'd2;
        req = (NM'(1) << 0) | (NM'(1) << 2) | (NM'(1) << 9) | (NM'(1) << 10);
        step();
        check("R3 highest priority wins", int'(owner), 9);
        req = '0; step();
        prio = '0;
    endtask

    task automatic t_rr();
        seed_ptr(6);
        req = (NM'(1) << 4) | (NM'(1) << 8); step();
        check("R4 first after pointer", int'(owner), 8);
        req = '0; step();
        req = (NM'(1) << 4) | (NM'(1) << 8); step();
        check("R4 wraps to m4", int'(owner), 4);
        req = '0; step();
    endtask

    task automatic t_slot();
        int held;
        seed_ptr(11);
        lim = 9'd4; rearb = 1'b1;
        req = 12'b11; step();
        held = 0;
        for (int c = 0; c < 10 && grant == 12'b01; c++) begin
            held++; step();
        end
        check("R5 hold cycles m0", held, 4);
        check("R5 moved to m1", int'(grant), 2);
        held = 0;
        for (int c = 0; c < 10 && grant == 12'b10; c++) begin
            held++; step();
        end
        check("R5 hold cycles m1", held, 4);
        req = '0; step();
    endtask

    task automatic t_rearb();
        seed_ptr(11);
        lim = 9'd2; rearb = 1'b0; req = 12'b11; step();
        check("R10 grant without rearb", int'(grant), 1);
        for (int c = 0; c < 8; c++) step();
        check("R6 held while rearb low", int'(grant), 1);
        rearb = 1'b1; step();
        check("R6 moves at rearb point", int'(grant), 2);
        req = '0; step();
    endtask

    task automatic t_unlimited();
        seed_ptr(11);
        lim = 9'd0; rearb = 1'b1; req = 12'b11; step();
        for (int c = 0; c < 20; c++) step();
        check("R5 zero limit unlimited", int'(grant), 1);
        req = '0; step();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #5 rst_n = 1'b1;
        step();
        t_reset();
        t_none();
        t_last();
        t_fixed();
        t_prio();
        t_rr();
        t_slot();
        t_rearb();
        t_unlimited();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule